// File: doc/BRIEF.md
# Multi-Channel SAR Scan Sequencer

This block sequences a successive-approximation converter across a bank of analog input channels. Configuration inputs supply a channel-enable mask, a preferred starting channel, a scan mode and the result resolution. Once a start strobe is accepted, the sequencer selects a channel and holds the sample phase for a fixed number of clocks. It then drives trial codes MSB first and keeps or drops each trial bit according to a comparator input. When the conversion finishes, it writes the result together with its channel index and sets that channel's done flag.

Disabled channels are skipped. Channel search wraps from the highest index back to 0. Three scan modes are available. In step mode, each command converts one channel. In single-pass mode, every enabled channel is converted once. In continuous mode, the enabled channels are cycled without end. An abort input returns the block to idle at once and discards any partial result. The channel count must be a power of two.

Top module: `scan_seq`

## Requirements
- R1: During and after reset the block is idle: `busy`, `wr_en`, `sample_en` are 0, `trial`, `ch_sel` and `done_flags` are all zero.
- R2: A start while `cfg_en_mask` is all zero is ignored: the block stays idle and writes nothing.
- R3: An accepted start converts first the channel `cfg_first_ch` if its mask bit is set, otherwise the next enabled channel above it, wrapping from NCH-1 to 0.
- R4: Each conversion keeps `sample_en` high, with `trial` zero, for the SMP=4 clocks following the start edge. It then runs one trial per clock and pulses `wr_en` for one cycle exactly 14 clock edges (10-bit, `cfg_res10`=1) or 12 edges (8-bit) after the conversion began.
- R5: Trials go MSB first. The first trial code is 1 shifted to bit 9 (10-bit) or bit 7 (8-bit). A trial bit is kept when `cmp_in`=1 in its cycle. The written result is right-aligned in `wr_data`, and the upper bits are zero in 8-bit mode.
- R6: Channels follow one another in ascending order with wrap-around, skipping disabled ones, and `wr_ch` gives the converted channel.
- R7: Step mode (`cfg_mode`=2'b00): each start converts one channel and the block then waits, idle, with no further writes. The next start converts the next enabled channel.
- R8: Single-pass mode (`cfg_mode`=2'b01): each enabled channel is written exactly once, then `busy` falls in the same cycle as the last `wr_en`.
- R9: Continuous mode (`cfg_mode`=2'b10 or 2'b11): conversions repeat back to back over the enabled channels until aborted.
- R10: When `abort` is high at a clock edge, the block is idle after that edge, and no write from the interrupted conversion ever appears.
- R11: `done_flags[c]` is set in the cycle channel c is written. All flags clear when a start is accepted from idle, and they persist across step-mode commands.
- R12: A start arriving while a conversion runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en_mask | input | NCH | Channel enable mask |
| cfg_first_ch | input | CW | Preferred starting channel |
| cfg_mode | input | 2 | 00 step, 01 single pass, 1x continuous |
| cfg_res10 | input | 1 | 1: 10-bit, 0: 8-bit result |
| start | input | 1 | Start / step command strobe |
| abort | input | 1 | Return to idle, drop partial result |
| cmp_in | input | 1 | Comparator: 1 when input is at or above trial code |
| ch_sel | output | CW | Selected analog channel |
| sample_en | output | 1 | Sample phase active |
| trial | output | RESW | Trial code for the DAC |
| wr_en | output | 1 | Result write strobe |
| wr_ch | output | CW | Channel of the written result |
| wr_data | output | RESW | Conversion result |
| done_flags | output | NCH | Per-channel done flags |
| busy | output | 1 | Conversion in progress |

## Verification
The bench builds the block with its defaults: eight channels, 10-bit full resolution, 8-bit reduced resolution and a four-clock sample phase. Eight channels make the wrap from channel 7 to 0 reachable with sparse masks. Both resolutions are exercised, so the 14-clock and 12-clock write spacing can be checked. A comparator model driven by fixed per-channel input codes makes each result predictable, including all-ones, zero and mid-scale codes.

// File: rtl/scan_seq.sv
module scan_seq #(
  parameter int NCH  = 8,
  parameter int RESW = 10,
  parameter int LOW  = 8,
  parameter int SMP  = 4,
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CNTW = $clog2(SMP + RESW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  cfg_en_mask,
  input  logic [CW-1:0]   cfg_first_ch,
  input  logic [1:0]      cfg_mode,
  input  logic            cfg_res10,
  input  logic            start,
  input  logic            abort,
  input  logic            cmp_in,
  output logic [CW-1:0]   ch_sel,
  output logic            sample_en,
  output logic [RESW-1:0] trial,
  output logic            wr_en,
  output logic [CW-1:0]   wr_ch,
  output logic [RESW-1:0] wr_data,
  output logic [NCH-1:0]  done_flags,
  output logic            busy
);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_HOLD} st_t;

  st_t             st;
  logic [CNTW-1:0] cnt;
  logic [CW-1:0]   ch, ptr;
  logic [RESW-1:0] acc;
  logic            res_q;

  function automatic logic [CW-1:0] pick(input logic [NCH-1:0] m, input logic [CW-1:0] p);
    logic [CW-1:0] r, i;
    logic hit;
    r = p;
    hit = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      i = p + CW'(k);
      if (!hit && m[i]) begin
        r = i;
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  logic [CNTW-1:0] nbits, bitpos;
  logic            in_trial, last;
  logic [RESW-1:0] acc_n;
  logic [NCH-1:0]  flags_n;
  logic            pass_end;
  logic [CW-1:0]   nxt;

  assign nbits    = res_q ? CNTW'(RESW) : CNTW'(LOW);
  assign in_trial = (st == S_CONV) && (cnt >= CNTW'(SMP));
  assign bitpos   = nbits - CNTW'(1) - (cnt - CNTW'(SMP));
  assign last     = in_trial && (bitpos == '0);
  assign trial    = in_trial ? (acc | (RESW'(1) << bitpos)) : '0;
  assign acc_n    = cmp_in ? trial : acc;
  assign flags_n  = done_flags | (NCH'(1) << ch);
  assign pass_end = (flags_n & cfg_en_mask) == cfg_en_mask;
  assign nxt      = pick(cfg_en_mask, ch + CW'(1));

  assign ch_sel    = ch;
  assign busy      = (st == S_CONV);
  assign sample_en = (st == S_CONV) && (cnt < CNTW'(SMP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      ch         <= '0;
      ptr        <= '0;
      acc        <= '0;
      res_q      <= 1'b0;
      wr_en      <= 1'b0;
      wr_ch      <= '0;
      wr_data    <= '0;
      done_flags <= '0;
    end else begin
      wr_en <= 1'b0;
      if (abort) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE, S_HOLD: begin
            if (start && (|cfg_en_mask)) begin
              st    <= S_CONV;
              cnt   <= '0;
              acc   <= '0;
              res_q <= cfg_res10;
              ch    <= pick(cfg_en_mask, (st == S_HOLD) ? ptr : cfg_first_ch);
              if (st == S_IDLE) done_flags <= '0;
            end
          end
          S_CONV: begin
            if (in_trial) acc <= acc_n;
            if (last) begin
              wr_en      <= 1'b1;
              wr_ch      <= ch;
              wr_data    <= acc_n;
              done_flags <= flags_n;
              cnt        <= '0;
              acc        <= '0;
              case (cfg_mode)
                2'b00: begin
                  st  <= S_HOLD;
                  ptr <= ch + CW'(1);
                end
                2'b01: begin
                  if (pass_end) st <= S_IDLE;
                  else ch <= nxt;
                end
                default: ch <= nxt;
              endcase
            end else begin
              cnt <= cnt + CNTW'(1);
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int NCH  = 8,
  parameter int RESW = 10,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCH-1:0]  cfg_en_mask,
  input logic            start,
  input logic            abort,
  input logic            sample_en,
  input logic [RESW-1:0] trial,
  input logic            wr_en,
  input logic [CW-1:0]   wr_ch,
  input logic [NCH-1:0]  done_flags,
  input logic            busy
);

  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !wr_en));

  a_r4_write_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  a_r4_sample_no_trial: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> (busy && trial == '0));

  a_r11_flag_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> done_flags[wr_ch]);

  a_r2_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !abort && cfg_en_mask == '0) |=> !busy);

  a_r6_write_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cfg_en_mask[wr_ch]);

  a_r4_write_after_conv: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(busy));

endmodule

bind scan_seq scan_seq_chk #(.NCH(NCH), .RESW(RESW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en_mask(cfg_en_mask), .start(start),
  .abort(abort), .sample_en(sample_en), .trial(trial), .wr_en(wr_en),
  .wr_ch(wr_ch), .done_flags(done_flags), .busy(busy)
);

// File: tb/scan_seq_test.sv
`timescale 1ns/1ps
module scan_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_en_mask = '0;
  logic [2:0] cfg_first_ch = '0;
  logic [1:0] cfg_mode = 2'b01;
  logic       cfg_res10 = 1'b1;
  logic       start = 1'b0;
  logic       abort = 1'b0;
  logic       cmp_in;
  logic [2:0] ch_sel;
  logic       sample_en;
  logic [9:0] trial;
  logic       wr_en;
  logic [2:0] wr_ch;
  logic [9:0] wr_data;
  logic [7:0] done_flags;
  logic       busy;

  logic [9:0] vin [8];
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  assign cmp_in = cfg_res10 ? (vin[ch_sel] >= trial)
                            : ({2'b00, vin[ch_sel][9:2]} >= trial);

  scan_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_en_mask(cfg_en_mask), .cfg_first_ch(cfg_first_ch),
    .cfg_mode(cfg_mode), .cfg_res10(cfg_res10), .start(start), .abort(abort),
    .cmp_in(cmp_in), .ch_sel(ch_sel), .sample_en(sample_en), .trial(trial),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data), .done_flags(done_flags),
    .busy(busy)
  );

  // mask, first, res10, count, sequence (entry i at bits 3i+2:3i)
  localparam logic [39:0] TBL [5] = '{
    {8'hFF, 3'd0, 1'b1, 4'd8, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}},
    {8'hA5, 3'd3, 1'b0, 4'd4, {3'd0,3'd0,3'd0,3'd0,3'd2,3'd0,3'd7,3'd5}},
    {8'h80, 3'd7, 1'b1, 4'd1, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd7}},
    {8'h13, 3'd5, 1'b1, 4'd3, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd4,3'd1,3'd0}},
    {8'h42, 3'd6, 1'b0, 4'd2, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd1,3'd6}}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_start;
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  function automatic int expd(input logic [2:0] c, input logic r);
    return r ? int'(vin[c]) : int'(vin[c] >> 2);
  endfunction

  task automatic wait_idle;
    for (int i = 0; i < 100; i++) begin
      if (!busy) break;
      tick();
    end
  endtask

  task automatic run_pass(input logic [39:0] e);
    logic [7:0] m;
    logic [23:0] sq;
    int n, nn, k, got;
    logic [2:0] ex;
    m = e[39:32];
    n = int'(e[27:24]);
    sq = e[23:0];
    cfg_en_mask = m;
    cfg_first_ch = e[31:29];
    cfg_res10 = e[28];
    cfg_mode = 2'b01;
    nn = e[28] ? 14 : 12;
    pulse_start();
    chk(busy == 1'b1, "R3 busy after start", busy, 1);
    k = 0;
    got = 0;
    for (int i = 0; i < 200; i++) begin
      tick();
      k++;
      if (wr_en) begin
        ex = sq[3*got +: 3];
        chk(wr_ch == ex, got == 0 ? "R3 first channel" : "R6 channel order", wr_ch, ex);
        chk(int'(wr_data) == expd(ex, e[28]), "R5 result", wr_data, expd(ex, e[28]));
        chk(k == (got + 1) * nn, "R4 write timing", k, (got + 1) * nn);
        got++;
      end
      if (!busy) break;
    end
    chk(got == n, "R8 writes per pass", got, n);
    chk(done_flags == m, "R11 flags after pass", done_flags, m);
  endtask

  task automatic wait_write(output int k);
    k = 0;
    for (int i = 0; i < 60; i++) begin
      tick();
      k++;
      if (wr_en) break;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k, seen;
    vin[0] = 10'h3FF; vin[1] = 10'h000; vin[2] = 10'h2AA; vin[3] = 10'h155;
    vin[4] = 10'h200; vin[5] = 10'h1FF; vin[6] = 10'h001; vin[7] = 10'h37C;

    tick(); tick();
    chk(!busy && !wr_en && !sample_en, "R1 reset controls", {busy, wr_en, sample_en}, 0);
    chk(trial == 0 && ch_sel == 0 && done_flags == 0, "R1 reset data", {trial, ch_sel, done_flags}, 0);
    rst_n = 1'b1;
    tick();

    // R2: empty mask
    cfg_en_mask = 8'h00;
    pulse_start();
    chk(!busy, "R2 start ignored", busy, 0);
    seen = 0;
    for (int i = 0; i < 20; i++) begin tick(); if (wr_en || busy) seen++; end
    chk(seen == 0, "R2 no activity", seen, 0);

    // table of single-pass scans
    for (int t = 0; t < 5; t++) begin
      run_pass(TBL[t]);
      tick();
    end

    // R4/R5: sample phase and first trials, 10-bit
    cfg_en_mask = 8'h01; cfg_first_ch = 3'd0; cfg_res10 = 1'b1; cfg_mode = 2'b01;
    pulse_start();
    for (int i = 0; i < 4; i++) begin
      chk(sample_en && trial == 0, "R4 sample phase", {sample_en, trial}, 11'h400);
      tick();
    end
    chk(!sample_en && trial == 10'h200, "R5 first trial 10-bit", trial, 10'h200);
    tick();
    chk(trial == 10'h300, "R5 second trial keeps MSB", trial, 10'h300);
    wait_idle();
    tick();

    // R5: 8-bit first trial
    cfg_res10 = 1'b0;
    pulse_start();
    tick(); tick(); tick(); tick();
    chk(trial == 10'h080, "R5 first trial 8-bit", trial, 10'h080);
    wait_idle();
    tick();

    // R12: start while busy
    cfg_res10 = 1'b1;
    pulse_start();
    for (int i = 0; i < 5; i++) tick();
    cfg_first_ch = 3'd3;
    pulse_start();
    k = 6;
    for (int i = 0; i < 40; i++) begin
      if (wr_en) break;
      tick(); k++;
    end
    chk(k == 14 && wr_ch == 0, "R12 timing unchanged", k, 14);
    seen = 0;
    for (int i = 0; i < 30; i++) begin tick(); if (wr_en) seen++; end
    chk(seen == 0, "R12 no extra conversion", seen, 0);

    // R7: step mode
    cfg_en_mask = 8'hA5; cfg_first_ch = 3'd3; cfg_mode = 2'b00; cfg_res10 = 1'b1;
    pulse_start();
    wait_write(k);
    chk(k == 14 && wr_ch == 3'd5, "R7 step 1 channel", wr_ch, 5);
    chk(!busy, "R7 waits after step", busy, 0);
    seen = 0;
    for (int i = 0; i < 20; i++) begin tick(); if (wr_en || busy) seen++; end
    chk(seen == 0, "R7 no self advance", seen, 0);
    pulse_start();
    wait_write(k);
    chk(wr_ch == 3'd7, "R7 step 2 channel", wr_ch, 7);
    pulse_start();
    wait_write(k);
    chk(wr_ch == 3'd0 && int'(wr_data) == expd(3'd0, 1'b1), "R7 step 3 wraps", wr_ch, 0);
    chk(done_flags == 8'hA1, "R11 flags kept across steps", done_flags, 8'hA1);
    tick();
    abort = 1'b1; tick(); abort = 1'b0;
    pulse_start();
    chk(done_flags == 8'h00, "R11 flags cleared on start", done_flags, 0);
    wait_write(k);
    chk(wr_ch == 3'd5, "R7 restart from first channel", wr_ch, 5);
    chk(done_flags == 8'h20, "R11 flag set on write", done_flags, 8'h20);
    tick();
    abort = 1'b1; tick(); abort = 1'b0;

    // R9/R10: continuous then abort
    cfg_en_mask = 8'h12; cfg_first_ch = 3'd4; cfg_mode = 2'b10; cfg_res10 = 1'b0;
    pulse_start();
    for (int n = 0; n < 5; n++) begin
      wait_write(k);
      chk(k == 12 && wr_ch == ((n % 2 == 0) ? 3'd4 : 3'd1), "R9 continuous cycle", {k, wr_ch},
          {12, (n % 2 == 0) ? 3'd4 : 3'd1});
    end
    chk(busy, "R9 still running", busy, 1);
    tick(); tick(); tick(); tick(); tick();
    abort = 1'b1; tick(); abort = 1'b0;
    chk(!busy && !wr_en, "R10 idle after abort", {busy, wr_en}, 0);
    seen = 0;
    for (int i = 0; i < 40; i++) begin tick(); if (wr_en || busy) seen++; end
    chk(seen == 0, "R10 no partial write", seen, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule